// File: doc/BRIEF.md
# Flat-Nested Two-Dimensional Page Walker

This block serves one TLB miss at a time for a virtual machine. It takes a 48-bit guest virtual address and produces the system physical address behind it. It walks a four-level guest page table whose root is given as a guest-physical address. Each guest-physical address the walk meets is a table root, a table frame or the final data page. Each one is converted to a system frame by a single indexed read of a flat nested table. No multi-level nested walk is done. A complete walk therefore costs nine memory reads, where a radix nested walk would cost twenty-four.

The walker talks to memory through a plain read port. It raises a one-cycle read request with a byte address and then waits for a response strobe that carries the 8-byte entry. It never has more than one read in flight. When the walk ends, a one-cycle completion strobe presents either the translated address or a fault, and the fault names the stage that failed.

Top module: `flatwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1 and `mem_rd_valid` and `done_valid` are 0.
- R2: A walk that succeeds issues exactly nine reads. Each read is a one-cycle `mem_rd_valid` pulse, and no new pulse appears until `mem_rsp_valid` has answered the previous one.
- R3: A nested read goes to byte address `nest_base + gPPN*8`, where gPPN is bits 31:12 of the guest-physical address being converted. A nested entry's system frame number is its bits 47:12; bits 63:48 are ignored.
- R4: A guest read goes to byte address `sysframe*4096 + index*8`. Here sysframe is the frame returned by the previous nested read, and index is the guest VA field for that level: bits 47:39, 38:30, 29:21 and 20:12, top level first. A guest entry's guest frame number is its bits 31:12; bits 63:32 are ignored.
- R5: Reads alternate in a fixed order. The first is a nested read for the guest root. Then come a guest read and a nested read for each of the four levels, top level first. The last read is the nested read for the data page.
- R6: On success `done_spa` equals the frame number from the ninth read, followed by guest VA bits 11:0, and `done_fault` is 0.
- R7: A guest entry with bit 0 clear ends the walk with `done_fault`=1 and `done_stage`=0. No further reads are issued.
- R8: A nested entry with bit 0 clear ends the walk with `done_fault`=1 and `done_stage`=1. No further reads are issued.
- R9: `req_valid`, `req_gva`, `guest_root` and `nest_base` are sampled only when a walk starts. Changes to them during a walk have no effect on its reads or its result.
- R10: `done_valid` is high for exactly one cycle, and `req_ready` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (accepted when `req_ready` is 1) |
| req_gva | input | 48 | Guest virtual address to translate |
| guest_root | input | 32 | Guest-physical base of the top-level guest table |
| nest_base | input | 48 | System-physical base of the flat nested table |
| req_ready | output | 1 | Walker idle, can accept a request |
| mem_rd_valid | output | 1 | One-cycle read request |
| mem_rd_addr | output | 48 | Byte address of the 8-byte entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done_valid | output | 1 | One-cycle completion strobe |
| done_spa | output | 48 | Translated system physical address |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_stage | output | 1 | Failing stage: 0 guest, 1 nested |

## Verification
A wrong step counter or a lost guest/nested phase bit shows up on the next `mem_rd_addr`. That address is one read after the fault, and the stimulus memory answers with a zero entry, so a fault completion follows within one response latency. A stale frame register corrupts the following read address or `done_spa`, and a present-bit slip turns into a wrong fault stage or a wrong read count at the completion strobe. The one-outstanding rule is watched on every cycle of every response wait.

// File: rtl/pw_pkg.sv
package pw_pkg;

  localparam int GVA_W  = 48;
  localparam int GPA_W  = 32;
  localparam int SPA_W  = 48;
  localparam int PG_SH  = 12;
  localparam int IDX_W  = 9;
  localparam int LVLS   = 4;
  localparam int ENT_W  = 64;
  localparam int ENT_SH = 3;

  localparam int GPPN_W = GPA_W - PG_SH;
  localparam int SFN_W  = SPA_W - PG_SH;
  localparam int STEPS  = 2 * LVLS + 1;
  localparam int STEP_W = $clog2(STEPS + 1);
  localparam int LVL_W  = (LVLS > 1) ? $clog2(LVLS) : 1;
  localparam int CNT_W  = $clog2(STEPS + 2);

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_ISSUE,
    WS_WAIT,
    WS_DONE
  } walk_st_e;

  typedef enum logic {
    FLT_GUEST  = 1'b0,
    FLT_NESTED = 1'b1
  } flt_stage_e;

  function automatic logic [IDX_W-1:0] level_index(input logic [GVA_W-1:0] gva,
                                                   input int lvl);
    int sh;
    sh = PG_SH + IDX_W * (LVLS - 1 - lvl);
    return IDX_W'(gva >> sh);
  endfunction

  function automatic logic [SPA_W-1:0] nested_addr(input logic [SPA_W-1:0]  nbase,
                                                   input logic [GPPN_W-1:0] gppn);
    return nbase + (SPA_W'(gppn) << ENT_SH);
  endfunction

  function automatic logic [SPA_W-1:0] guest_addr(input logic [SFN_W-1:0] sfn,
                                                  input logic [IDX_W-1:0] idx);
    return {sfn, {PG_SH{1'b0}}} + (SPA_W'(idx) << ENT_SH);
  endfunction

  function automatic logic [SPA_W-1:0] compose_spa(input logic [SFN_W-1:0] sfn,
                                                   input logic [GVA_W-1:0] gva);
    return {sfn, gva[PG_SH-1:0]};
  endfunction

endpackage

// File: rtl/pw_entry_dec.sv
module pw_entry_dec
  import pw_pkg::*;
(
  input  logic [ENT_W-1:0]  entry_i,
  output logic              present_o,
  output logic [GPPN_W-1:0] gfn_o,
  output logic [SFN_W-1:0]  sfn_o
);

  always_comb begin
    present_o = entry_i[0];
    gfn_o     = entry_i[GPA_W-1:PG_SH];
    sfn_o     = entry_i[SPA_W-1:PG_SH];
  end

endmodule

// File: rtl/pw_addr_sel.sv
module pw_addr_sel
  import pw_pkg::*;
(
  input  logic              nested_step_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [SPA_W-1:0]  nbase_i,
  input  logic [GPPN_W-1:0] gfn_i,
  input  logic [SFN_W-1:0]  sfn_i,
  input  logic [GVA_W-1:0]  gva_i,
  output logic [SPA_W-1:0]  addr_o
);

  logic [SPA_W-1:0] guest_cand [LVLS];
  logic [LVL_W-1:0] lvl;
  logic [SPA_W-1:0] nest_cand;

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    assign guest_cand[g] = guest_addr(sfn_i, level_index(gva_i, g));
  end

  always_comb begin
    lvl       = LVL_W'(step_i >> 1);
    nest_cand = nested_addr(nbase_i, gfn_i);
    addr_o    = nested_step_i ? nest_cand : guest_cand[lvl];
  end

endmodule

// File: rtl/pw_seq.sv
module pw_seq
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rsp_valid_i,
  input  logic              entry_ok_i,
  output walk_st_e          state_o,
  output logic [STEP_W-1:0] step_o,
  output logic              issue_o,
  output logic              nested_step_o,
  output logic              advance_o,
  output logic              finish_o,
  output logic              fault_o
);

  walk_st_e          state_q;
  logic [STEP_W-1:0] step_q;
  logic              last_step;
  logic              take;

  always_comb begin
    nested_step_o = ~step_q[0];
    last_step     = (step_q == STEP_W'(STEPS - 1));
    take          = (state_q == WS_WAIT) && rsp_valid_i;
    fault_o       = take && !entry_ok_i;
    finish_o      = take && entry_ok_i && last_step;
    advance_o     = take && entry_ok_i && !last_step;
    issue_o       = (state_q == WS_ISSUE);
    state_o       = state_q;
    step_o        = step_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        WS_IDLE: if (start_i) begin
          state_q <= WS_ISSUE;
          step_q  <= '0;
        end
        WS_ISSUE: state_q <= WS_WAIT;
        WS_WAIT: begin
          if (fault_o || finish_o) begin
            state_q <= WS_DONE;
          end else if (advance_o) begin
            state_q <= WS_ISSUE;
            step_q  <= step_q + 1'b1;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  // R2: a request is a single-cycle pulse
  p_issue_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o);

  // R5: each accepted entry flips between nested and guest phases
  p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |=> (issue_o && (nested_step_o != $past(nested_step_o))));

  // R10: completion lasts one cycle
  p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_DONE) |=> (state_q == WS_IDLE));

  // R2: step never passes the ninth read
  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != WS_IDLE) |-> (step_q < STEP_W'(STEPS)));

endmodule

// File: rtl/flatwalk_top.sv
module flatwalk_top
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [GVA_W-1:0]  req_gva,
  input  logic [GPA_W-1:0]  guest_root,
  input  logic [SPA_W-1:0]  nest_base,
  output logic              req_ready,
  output logic              mem_rd_valid,
  output logic [SPA_W-1:0]  mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic [SPA_W-1:0]  done_spa,
  output logic              done_fault,
  output logic              done_stage
);

  walk_st_e          state;
  logic [STEP_W-1:0] step;
  logic              issue_evt;
  logic              nested_step;
  logic              advance_evt;
  logic              finish_evt;
  logic              fault_evt;
  logic              start_evt;

  logic              ent_present;
  logic [GPPN_W-1:0] ent_gfn;
  logic [SFN_W-1:0]  ent_sfn;

  logic [GVA_W-1:0]  gva_q;
  logic [SPA_W-1:0]  nbase_q;
  logic [GPPN_W-1:0] gfn_q;
  logic [SFN_W-1:0]  sfn_q;
  logic [SPA_W-1:0]  spa_q;
  logic              fault_q;
  flt_stage_e        stage_q;
  logic [CNT_W-1:0]  walk_reads;

  assign req_ready = (state == WS_IDLE);
  assign start_evt = req_ready && req_valid;

  pw_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_evt),
    .rsp_valid_i   (mem_rsp_valid),
    .entry_ok_i    (ent_present),
    .state_o       (state),
    .step_o        (step),
    .issue_o       (issue_evt),
    .nested_step_o (nested_step),
    .advance_o     (advance_evt),
    .finish_o      (finish_evt),
    .fault_o       (fault_evt)
  );

  pw_entry_dec u_dec (
    .entry_i   (mem_rsp_data),
    .present_o (ent_present),
    .gfn_o     (ent_gfn),
    .sfn_o     (ent_sfn)
  );

  pw_addr_sel u_addr (
    .nested_step_i (nested_step),
    .step_i        (step),
    .nbase_i       (nbase_q),
    .gfn_i         (gfn_q),
    .sfn_i         (sfn_q),
    .gva_i         (gva_q),
    .addr_o        (mem_rd_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gva_q   <= '0;
      nbase_q <= '0;
      gfn_q   <= '0;
      sfn_q   <= '0;
      spa_q   <= '0;
      fault_q <= 1'b0;
      stage_q <= FLT_GUEST;
    end else begin
      if (start_evt) begin
        gva_q   <= req_gva;
        nbase_q <= nest_base;
        gfn_q   <= guest_root[GPA_W-1:PG_SH];
      end
      if (advance_evt) begin
        if (nested_step) sfn_q <= ent_sfn;
        else             gfn_q <= ent_gfn;
      end
      if (finish_evt) begin
        spa_q   <= compose_spa(ent_sfn, gva_q);
        fault_q <= 1'b0;
      end
      if (fault_evt) begin
        fault_q <= 1'b1;
        stage_q <= nested_step ? FLT_NESTED : FLT_GUEST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         walk_reads <= '0;
    else if (start_evt) walk_reads <= '0;
    else if (issue_evt) walk_reads <= walk_reads + 1'b1;
  end

  assign mem_rd_valid = issue_evt;
  assign done_valid   = (state == WS_DONE);
  assign done_spa     = spa_q;
  assign done_fault   = fault_q;
  assign done_stage   = stage_q;

  // R2: a successful walk used exactly nine reads
  p_nine_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (walk_reads == CNT_W'(STEPS)));

  // R7: guest reads are the even-numbered ones
  p_guest_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault && (done_stage == FLT_GUEST)) |-> !walk_reads[0]);

  // R8: nested reads are the odd-numbered ones
  p_nested_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault && (done_stage == FLT_NESTED)) |-> walk_reads[0]);

  // R6: the page offset passes straight through
  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_spa[PG_SH-1:0] == gva_q[PG_SH-1:0]));

  // R9: the captured address holds while busy
  p_gva_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(gva_q));

  // R10: ready comes back right after completion
  p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (req_ready && !done_valid));

endmodule

// File: tb/flatwalk_top_bench.sv
module flatwalk_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_gva = '0;
  logic [31:0] guest_root = '0;
  logic [47:0] nest_base = '0;
  logic        req_ready;
  logic        mem_rd_valid;
  logic [47:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [47:0] done_spa;
  logic        done_fault;
  logic        done_stage;

  always #5 clk = ~clk;

  flatwalk_top u_flatwalk_top (.*);

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int overlap = 0;
  int addr_bad = 0;
  logic [47:0] rd_log [16];
  logic [63:0] mem [logic [47:0]];
  logic [47:0] exp_a [9];
  logic [35:0] sf [5];
  logic [19:0] gf [5];

  // {fault step (9 = none), gva}
  localparam logic [51:0] VEC [9] = '{
    {4'd9, 48'h7FFF_FFFF_F123},
    {4'd9, 48'h0000_0000_0000},
    {4'd9, 48'hFFFF_FFFF_FFFF},
    {4'd9, 48'h1234_5678_9ABC},
    {4'd3, 48'hABCD_EF01_2345},
    {4'd0, 48'h0000_8040_2ABC},
    {4'd8, 48'h5555_AAAA_5555},
    {4'd7, 48'h0F0F_0F0F_0F0F},
    {4'd1, 48'h3000_0000_1FFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: 1..3 cycle latency, watches for a second request
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_rd_valid) begin
        automatic logic [47:0] a = mem_rd_addr;
        automatic int lat = 1 + (rd_cnt % 3);
        if (rd_cnt < 16) rd_log[rd_cnt] = a;
        rd_cnt++;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          if (mem_rd_valid) overlap++;
        end
        mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
        mem_rsp_valid = 1'b1;
      end
    end
  end

  task automatic build(input int k, input logic [47:0] gva, input int f,
                       output logic [47:0] nb, output logic [31:0] root);
    mem.delete();
    nb   = 48'h0000_8000_0000 + 48'(k) * 48'h100_0000;
    root = {20'h00010 + 20'(k), 12'h5A0};
    for (int j = 0; j < 5; j++) begin
      gf[j] = (j == 0) ? root[31:12] : 20'h01000 + 20'(k * 64 + j * 7);
      sf[j] = 36'h0_000A_0000 + 36'(k * 64 + j * 9);
    end
    for (int s = 0; s < 9; s++) begin
      logic [63:0] e;
      if (s % 2 == 0) begin
        exp_a[s] = nb + {25'h0, gf[s/2], 3'b000};
        e = {16'h8000, sf[s/2], 12'h0E1};
      end else begin
        exp_a[s] = {sf[s/2], 12'h000} + {36'h0, gva[47 - 9*(s/2) -: 9], 3'b000};
        e = {16'hA5A5, 16'h0000, gf[s/2 + 1], 12'h063};
      end
      if (s == f) e[0] = 1'b0;
      mem[exp_a[s]] = e;
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done_valid) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: no completion actual=0 expected=1");
    end
  endtask

  task automatic start_walk(input logic [47:0] gva, input logic [47:0] nb,
                            input logic [31:0] root);
    @(negedge clk);
    rd_cnt = 0; overlap = 0;
    req_gva = gva; nest_base = nb; guest_root = root; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic judge(input logic [47:0] gva, input int f, input bit ok);
    int nrd;
    if (!ok) return;
    nrd = (f == 9) ? 9 : f + 1;
    if (f == 9) begin
      chk(!done_fault, "R6 fault flag", 64'(done_fault), 64'd0);
      chk(done_spa == {sf[4], gva[11:0]}, "R6 result", 64'(done_spa),
          64'({sf[4], gva[11:0]}));
      chk(rd_cnt == 9, "R2 read count", 64'(rd_cnt), 64'd9);
    end else begin
      chk(done_fault, (f % 2) ? "R7 fault flag" : "R8 fault flag", 64'(done_fault), 64'd1);
      chk(done_stage == ((f % 2) ? 1'b0 : 1'b1), (f % 2) ? "R7 stage" : "R8 stage",
          64'(done_stage), 64'((f % 2) ? 0 : 1));
      chk(rd_cnt == nrd, (f % 2) ? "R7 stops" : "R8 stops", 64'(rd_cnt), 64'(nrd));
    end
    addr_bad = 0;
    for (int s = 0; s < nrd && s < 16; s++)
      if (rd_log[s] !== exp_a[s]) begin
        addr_bad++;
        $display("FAIL R3 R4 R5 read %0d actual=%h expected=%h", s, rd_log[s], exp_a[s]);
      end
    n_chk++;
    if (addr_bad != 0) n_bad++;
    chk(overlap == 0, "R2 one outstanding", 64'(overlap), 64'd0);
    @(negedge clk);
    chk(!done_valid && req_ready, "R10 one-cycle done", 64'({done_valid, req_ready}), 64'b01);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL global watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] nb;
    logic [31:0] root;
    bit ok;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_valid && !done_valid, "R1 reset state",
        64'({req_ready, mem_rd_valid, done_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_rd_valid && !done_valid, "R1 idle after reset",
        64'({req_ready, mem_rd_valid, done_valid}), 64'b100);

    for (int k = 0; k < 9; k++) begin
      automatic logic [47:0] gva = VEC[k][47:0];
      automatic int f = int'(VEC[k][51:48]);
      build(k, gva, f, nb, root);
      start_walk(gva, nb, root);
      wait_done(ok);
      judge(gva, f, ok);
    end

    // R9: disturb every request input during a walk
    build(3, 48'h2468_ACE0_1357, 9, nb, root);
    start_walk(48'h2468_ACE0_1357, nb, root);
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_gva = 48'hFFFF_0000_FFFF;
    nest_base = 48'h1111_1111_1000; guest_root = 32'hDEAD_B000;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(ok);
    if (ok) chk(done_spa == {sf[4], 12'h357} && !done_fault, "R9 inputs ignored mid-walk",
                64'(done_spa), 64'({sf[4], 12'h357}));
    judge(48'h2468_ACE0_1357, 9, ok);
    chk(rd_cnt == 9, "R9 no second walk", 64'(rd_cnt), 64'd9);

    // R1: reset mid-walk returns to idle
    build(0, 48'h7FFF_FFFF_F123, 9, nb, root);
    start_walk(48'h7FFF_FFFF_F123, nb, root);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(req_ready && !done_valid && !mem_rd_valid, "R1 reset mid-walk",
        64'({req_ready, done_valid, mem_rd_valid}), 64'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    build(2, 48'hFFFF_FFFF_FFFF, 9, nb, root);
    start_walk(48'hFFFF_FFFF_FFFF, nb, root);
    wait_done(ok);
    judge(48'hFFFF_FFFF_FFFF, 9, ok);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule